// File: doc/BRIEF.md
# Two-Wire Wiper Register Controller

This block is the serial front end of a two-channel, 64-position digital potentiometer. It listens on a two-wire bus (clock and open-drain data, both sampled on the system clock), detects start and stop conditions, and checks the first byte of each transfer against a fixed device type code and four strap inputs. A matching address is followed by a command byte. The command byte holds an operation code and a pointer that picks one of the two pots and one of that pot's four data registers. The block then reads or writes a wiper register or a data register, or copies a value between a data register and the wiper register.

Each pot has a 6-bit wiper register. The wiper register is decoded into a one-hot, 64-line switch select output. Writes to a data register and stores from the wiper into a data register stand in for nonvolatile writes. When the stop condition closes such a transfer, a busy interval of a parameterised number of clock cycles begins. For that whole interval the block refuses to acknowledge its own address, so a bus master can poll until the write has finished.

Top module: `potw_ctrl`

## Requirements
- R1: The first byte after a start is acknowledged only if its bits 7:4 equal 4'b0101. Otherwise the block stays silent until the next start.
- R2: Bits 3:0 of the first byte must equal `strap_i` for the block to acknowledge.
- R3: The block drives an ACK (data held low during the ninth clock) after a matching address and after an accepted command byte. For write operations it also drives one after the single data byte. Any further byte in the same transfer gets no ACK and has no effect.
- R4: The command byte carries the operation in bits 7:4: 4'h9 read wiper, 4'hA write wiper, 4'hB read data register, 4'hC write data register, 4'hD data register to wiper, 4'hE wiper to data register. Bit 2 selects pot 0 or pot 1, and bits 1:0 select the data register. Any other operation code is not acknowledged and changes nothing.
- R5: Each select output has exactly one bit set, and that bit's index equals the pot's wiper value.
- R6: Written values take the low 6 bits of the data byte. A read returns one byte, MSB first, made of 2'b00 followed by the 6-bit register value.
- R7: Operation 4'hD copies the pointed data register into that pot's wiper register.
- R8: Operations 4'hC and 4'hE start a busy interval at the stop that ends the transfer. While busy, the address byte is not acknowledged. After the interval ends, the address is acknowledged again.
- R9: `busy_o` is high for exactly BUSY_CYCLES clock cycles for each busy interval.
- R10: A start or stop at any point abandons the current transfer. A start begins a new address byte, even in the middle of a byte. A stop before the data byte leaves all registers unchanged.
- R11: After reset, all wiper and data registers are zero, each select output is 1 (switch 0), `busy_o` is low and data is released.
- R12: The block changes its data drive only while the synchronised clock line is low, apart from the release caused by a start or stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| strap_i | input | 4 | Strapped device address bits |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| sel0_o | output | 64 | One-hot switch select, pot 0 |
| sel1_o | output | 64 | One-hot switch select, pot 1 |
| busy_o | output | 1 | Nonvolatile write interval in progress |

## Verification
The assertions check on every cycle that each select output stays one-hot and that an address ACK is never driven while busy. They also check that the data drive moves only while the clock line is low, that a stop sends the controller to idle, and that a busy interval starts in the cycle after it is requested. The bench scenarios are the only way to show the byte-level behaviour: address and strap matching, the command decode and pointer fields, read data values, transfers between registers, and ignored extra bytes. They also cover abandoned and restarted transfers, the exact length of the busy interval, and ACK polling during and after it.

// File: rtl/potw_pkg.sv
package potw_pkg;
    localparam int WIPER_W = 6;
    localparam int NTAPS   = 1 << WIPER_W;
    localparam int NPOTS   = 2;
    localparam int NREGS   = 4;
    localparam int RSEL_W  = $clog2(NREGS);
    localparam int BYTE_W  = 8;

    localparam logic [3:0] DEV_TYPE    = 4'b0101;
    localparam logic [3:0] OP_RD_WIPER = 4'h9;
    localparam logic [3:0] OP_WR_WIPER = 4'hA;
    localparam logic [3:0] OP_RD_DATA  = 4'hB;
    localparam logic [3:0] OP_WR_DATA  = 4'hC;
    localparam logic [3:0] OP_D2W      = 4'hD;
    localparam logic [3:0] OP_W2D      = 4'hE;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_CMD,
        ST_ACK_CMD,
        ST_WDATA,
        ST_ACK_DATA,
        ST_RDATA,
        ST_DONE
    } bus_state_e;

    function automatic logic op_known(input logic [3:0] op);
        return (op == OP_RD_WIPER) || (op == OP_WR_WIPER) ||
               (op == OP_RD_DATA)  || (op == OP_WR_DATA)  ||
               (op == OP_D2W)      || (op == OP_W2D);
    endfunction
endpackage

// File: rtl/potw_line_sync.sv
module potw_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_last;
        logic              sda_last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.scl_pipe = {s_q.scl_pipe[STAGES-2:0], scl_i};
        s_d.sda_pipe = {s_q.sda_pipe[STAGES-2:0], sda_i};
        s_d.scl_last = s_q.scl_pipe[STAGES-1];
        s_d.sda_last = s_q.sda_pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign scl_o      = s_q.scl_pipe[STAGES-1];
    assign sda_o      = s_q.sda_pipe[STAGES-1];
    assign scl_rise_o = scl_o & ~s_q.scl_last;
    assign scl_fall_o = ~scl_o & s_q.scl_last;
    assign start_o    = scl_o & s_q.scl_last & s_q.sda_last & ~sda_o;
    assign stop_o     = scl_o & s_q.scl_last & ~s_q.sda_last & sda_o;
endmodule

// File: rtl/potw_busy_timer.sv
module potw_busy_timer #(
    parameter int CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(CYCLES + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (start_i) begin
            t_d.busy = 1'b1;
            t_d.cnt  = CW'(CYCLES - 1);
        end else if (t_q.busy) begin
            if (t_q.cnt == '0) t_d.busy = 1'b0;
            else               t_d.cnt  = t_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign busy_o = t_q.busy;

    // R9
    busy_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);
endmodule

// File: rtl/potw_tap_decode.sv
module potw_tap_decode #(
    parameter int W = 6
) (
    input  logic [W-1:0]        tap_i,
    output logic [(1<<W)-1:0]   sel_o
);
    for (genvar i = 0; i < (1 << W); i++) begin : g_sw
        assign sel_o[i] = (tap_i == W'(i));
    end
endmodule

// File: rtl/potw_ctrl.sv
module potw_ctrl
    import potw_pkg::*;
#(
    parameter int BUSY_CYCLES = 5000,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [3:0]       strap_i,
    output logic             sda_oe_o,
    output logic [NTAPS-1:0] sel0_o,
    output logic [NTAPS-1:0] sel1_o,
    output logic             busy_o
);
    localparam int PAD_W = BYTE_W - WIPER_W;

    typedef struct packed {
        bus_state_e                                st;
        logic [BYTE_W-1:0]                         sh;
        logic [2:0]                                cnt;
        logic                                      got;
        logic [3:0]                                op;
        logic                                      pot;
        logic [RSEL_W-1:0]                         rsel;
        logic                                      oe;
        logic                                      nv_pend;
        logic [NPOTS-1:0][WIPER_W-1:0]             wiper;
        logic [NPOTS-1:0][NREGS-1:0][WIPER_W-1:0]  dreg;
    } ctl_t;

    ctl_t c_d, c_q;

    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic nv_go;

    potw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_ev),
        .stop_o     (stop_ev)
    );

    potw_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (nv_go),
        .busy_o  (busy_o)
    );

    always_comb begin
        logic [3:0]        op_n;
        logic              pot_n;
        logic [RSEL_W-1:0] reg_n;
        logic [BYTE_W-1:0] tx_n;

        c_d   = c_q;
        nv_go = 1'b0;
        op_n  = c_q.sh[7:4];
        pot_n = c_q.sh[2];
        reg_n = c_q.sh[RSEL_W-1:0];
        tx_n  = '0;

        if (start_ev) begin
            c_d.st      = ST_ADDR;
            c_d.cnt     = '0;
            c_d.got     = 1'b0;
            c_d.oe      = 1'b0;
            c_d.nv_pend = 1'b0;
        end else if (stop_ev) begin
            nv_go       = c_q.nv_pend;
            c_d.st      = ST_IDLE;
            c_d.oe      = 1'b0;
            c_d.nv_pend = 1'b0;
        end else begin
            unique case (c_q.st)
                ST_ADDR, ST_CMD, ST_WDATA: begin
                    if (scl_rise) begin
                        c_d.sh  = {c_q.sh[BYTE_W-2:0], sda_s};
                        c_d.cnt = c_q.cnt + 3'd1;
                        if (c_q.cnt == 3'd7) c_d.got = 1'b1;
                    end else if (scl_fall && c_q.got) begin
                        c_d.got = 1'b0;
                        c_d.cnt = '0;
                        c_d.st  = ST_IDLE;
                        if (c_q.st == ST_ADDR) begin
                            if (c_q.sh[7:4] == DEV_TYPE && c_q.sh[3:0] == strap_i && !busy_o) begin
                                c_d.st = ST_ACK_ADDR;
                                c_d.oe = 1'b1;
                            end
                        end else if (c_q.st == ST_CMD) begin
                            if (op_known(op_n)) begin
                                c_d.st   = ST_ACK_CMD;
                                c_d.oe   = 1'b1;
                                c_d.op   = op_n;
                                c_d.pot  = pot_n;
                                c_d.rsel = reg_n;
                                if (op_n == OP_D2W)
                                    c_d.wiper[pot_n] = c_q.dreg[pot_n][reg_n];
                                if (op_n == OP_W2D) begin
                                    c_d.dreg[pot_n][reg_n] = c_q.wiper[pot_n];
                                    c_d.nv_pend            = 1'b1;
                                end
                            end
                        end else begin
                            c_d.st = ST_ACK_DATA;
                            c_d.oe = 1'b1;
                            if (c_q.op == OP_WR_WIPER) begin
                                c_d.wiper[c_q.pot] = c_q.sh[WIPER_W-1:0];
                            end else begin
                                c_d.dreg[c_q.pot][c_q.rsel] = c_q.sh[WIPER_W-1:0];
                                c_d.nv_pend                 = 1'b1;
                            end
                        end
                    end
                end
                ST_ACK_ADDR: begin
                    if (scl_fall) begin
                        c_d.oe = 1'b0;
                        c_d.st = ST_CMD;
                    end
                end
                ST_ACK_CMD: begin
                    if (scl_fall) begin
                        c_d.oe  = 1'b0;
                        c_d.cnt = '0;
                        c_d.st  = ST_DONE;
                        if (c_q.op == OP_RD_WIPER || c_q.op == OP_RD_DATA) begin
                            if (c_q.op == OP_RD_WIPER)
                                tx_n = {{PAD_W{1'b0}}, c_q.wiper[c_q.pot]};
                            else
                                tx_n = {{PAD_W{1'b0}}, c_q.dreg[c_q.pot][c_q.rsel]};
                            c_d.sh = tx_n;
                            c_d.oe = ~tx_n[BYTE_W-1];
                            c_d.st = ST_RDATA;
                        end else if (c_q.op == OP_WR_WIPER || c_q.op == OP_WR_DATA) begin
                            c_d.st = ST_WDATA;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (c_q.cnt == 3'd7) begin
                            c_d.oe = 1'b0;
                            c_d.st = ST_DONE;
                        end else begin
                            c_d.cnt = c_q.cnt + 3'd1;
                            c_d.sh  = {c_q.sh[BYTE_W-2:0], 1'b0};
                            c_d.oe  = ~c_q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_ACK_DATA: begin
                    if (scl_fall) begin
                        c_d.oe = 1'b0;
                        c_d.st = ST_DONE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign sda_oe_o = c_q.oe;

    potw_tap_decode #(.W(WIPER_W)) u_dec0 (.tap_i(c_q.wiper[0]), .sel_o(sel0_o));
    potw_tap_decode #(.W(WIPER_W)) u_dec1 (.tap_i(c_q.wiper[1]), .sel_o(sel1_o));

    // R5
    sel0_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel0_o) == 1);
    // R5
    sel1_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel1_o) == 1);
    // R8
    busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_ACK_ADDR) |-> !busy_o);
    // R10
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (c_q.st == ST_IDLE && !sda_oe_o));
    // R12
    sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) && !$past(start_ev || stop_ev) |-> !scl_s);
endmodule

// File: tb/potw_ctrl_bench.sv
module potw_ctrl_bench;
    import potw_pkg::*;

    localparam int BUSY  = 400;
    localparam int HALF  = 8;
    localparam logic [3:0] STRAP = 4'hA;
    localparam logic [7:0] ADDR  = 8'h5A;

    typedef struct packed {
        logic [7:0] cmd;
        logic       has_wr;
        logic [7:0] wdata;
        logic       is_rd;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{8'hA0, 1'b1, 8'h15, 1'b0, 8'h00},
        '{8'h90, 1'b0, 8'h00, 1'b1, 8'h15},
        '{8'hA4, 1'b1, 8'hFF, 1'b0, 8'h00},
        '{8'h94, 1'b0, 8'h00, 1'b1, 8'h3F},
        '{8'hC2, 1'b1, 8'h2A, 1'b0, 8'h00},
        '{8'hB2, 1'b0, 8'h00, 1'b1, 8'h2A},
        '{8'hC7, 1'b1, 8'h07, 1'b0, 8'h00},
        '{8'hB7, 1'b0, 8'h00, 1'b1, 8'h07},
        '{8'hB1, 1'b0, 8'h00, 1'b1, 8'h00},
        '{8'hD2, 1'b0, 8'h00, 1'b0, 8'h00},
        '{8'h90, 1'b0, 8'h00, 1'b1, 8'h2A},
        '{8'hE4, 1'b0, 8'h00, 1'b0, 8'h00},
        '{8'hB4, 1'b0, 8'h00, 1'b1, 8'h3F}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [NTAPS-1:0] sel0, sel1;
    logic busy;

    assign sda_line = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    potw_ctrl #(.BUSY_CYCLES(BUSY)) u_potw_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .strap_i  (STRAP),
        .sda_oe_o (sda_oe),
        .sel0_o   (sel0),
        .sel1_o   (sel1),
        .busy_o   (busy)
    );

    int tests = 0;
    int fails = 0;
    int busy_run = 0;
    logic busy_prev = 1'b0;

    always @(negedge clk) begin
        if (busy && !busy_prev) busy_run = 1;
        else if (busy)          busy_run = busy_run + 1;
        busy_prev = busy;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_x(input logic b, output logic s);
        sda_m = b;
        tick(HALF - 2);
        scl_m = 1'b1;
        tick(HALF / 2);
        s = sda_line;
        tick(HALF / 2);
        scl_m = 1'b0;
        tick(2);
    endtask

    task automatic go_start;
        sda_m = 1'b1;
        tick(2);
        scl_m = 1'b1;
        tick(HALF);
        sda_m = 1'b0;
        tick(HALF);
        scl_m = 1'b0;
        tick(2);
    endtask

    task automatic go_stop;
        sda_m = 1'b0;
        tick(HALF - 2);
        scl_m = 1'b1;
        tick(HALF);
        sda_m = 1'b1;
        tick(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_x(b[i], s);
        bit_x(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_x(1'b1, s);
            b[i] = s;
        end
        bit_x(1'b1, s);
    endtask

    task automatic wait_idle;
        int g = 0;
        while (busy && g < 5000) begin
            tick(1);
            g++;
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        logic a;
        logic [7:0] r;
        go_start;
        send_byte(ADDR, a);
        chk($sformatf("R3 vec%0d address ack", idx), 64'(a), 64'd1);
        send_byte(v.cmd, a);
        chk($sformatf("R4 vec%0d command ack", idx), 64'(a), 64'd1);
        if (v.has_wr) begin
            send_byte(v.wdata, a);
            chk($sformatf("R3 vec%0d data ack", idx), 64'(a), 64'd1);
        end
        if (v.is_rd) begin
            recv_byte(r);
            chk($sformatf("R6 R7 vec%0d read value", idx), 64'(r), 64'(v.exp));
        end
        go_stop;
        tick(4);
        wait_idle;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic a;
        logic s;
        logic [7:0] r;

        tick(5);
        rst_n = 1'b1;
        tick(4);
        // R11 reset state
        chk("R11 sel0 after reset", sel0, 64'd1);
        chk("R11 sel1 after reset", sel1, 64'd1);
        chk("R11 busy after reset", 64'(busy), 64'd0);
        chk("R11 sda released after reset", 64'(sda_oe), 64'd0);
        go_start;
        send_byte(ADDR, a);
        send_byte(8'h90, a);
        recv_byte(r);
        go_stop;
        chk("R11 wiper 0 reads zero", 64'(r), 64'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R5 select follows wiper
        chk("R5 sel0 index", sel0, 64'd1 << 42);
        chk("R5 sel1 index", sel1, 64'd1 << 63);

        // R1 wrong type code
        go_start;
        send_byte(8'h6A, a);
        go_stop;
        chk("R1 wrong type code not acked", 64'(a), 64'd0);

        // R2 wrong strap bits
        go_start;
        send_byte(8'h5B, a);
        go_stop;
        chk("R2 strap mismatch not acked", 64'(a), 64'd0);

        // R4 unknown operation code
        go_start;
        send_byte(ADDR, a);
        send_byte(8'h50, a);
        chk("R4 unknown op not acked", 64'(a), 64'd0);
        send_byte(8'h01, a);
        go_stop;
        chk("R4 unknown op leaves sel0", sel0, 64'd1 << 42);

        // R3 extra byte not acked and ignored
        go_start;
        send_byte(ADDR, a);
        send_byte(8'hA4, a);
        send_byte(8'h05, a);
        send_byte(8'h09, a);
        chk("R3 extra byte not acked", 64'(a), 64'd0);
        go_stop;
        chk("R3 R5 extra byte ignored sel1", sel1, 64'd1 << 5);

        // R8 R9 busy interval and polling
        go_start;
        send_byte(ADDR, a);
        send_byte(8'hC0, a);
        send_byte(8'h11, a);
        go_stop;
        chk("R8 busy after nonvolatile write", 64'(busy), 64'd1);
        go_start;
        send_byte(ADDR, a);
        go_stop;
        chk("R8 address not acked while busy", 64'(a), 64'd0);
        wait_idle;
        tick(2);
        chk("R9 busy length", 64'(busy_run), 64'(BUSY));
        go_start;
        send_byte(ADDR, a);
        chk("R8 address acked after busy", 64'(a), 64'd1);
        send_byte(8'hB0, a);
        recv_byte(r);
        go_stop;
        chk("R6 data register after busy", 64'(r), 64'h11);

        // R10 repeated start in the middle of a byte
        go_start;
        for (int i = 7; i >= 4; i--) bit_x(ADDR[i], s);
        go_start;
        send_byte(ADDR, a);
        chk("R10 address acked after restart", 64'(a), 64'd1);
        send_byte(8'hA0, a);
        send_byte(8'h3C, a);
        go_stop;
        chk("R10 write after restart sel0", sel0, 64'd1 << 60);

        // R10 stop before data byte leaves wiper unchanged
        go_start;
        send_byte(ADDR, a);
        send_byte(8'hA4, a);
        go_stop;
        tick(4);
        chk("R10 abandoned write no busy", 64'(busy), 64'd0);
        chk("R10 abandoned write sel1", sel1, 64'd1 << 5);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule